// File: doc/BRIEF.md
# Watchdog Timer with Paired Clear

This block is the watchdog of a small microcontroller core. It counts ticks from one of three clock sources: a low-speed RC oscillator, a 32768 Hz crystal oscillator, or the instruction clock (the system clock divided by four). It requests a reset when software fails to clear it in time. Each clock source reaches the block as a one-cycle enable on the single system clock, so the whole block is synchronous. The instruction tick is derived inside the block.

Software clears the count in one of two ways, chosen by a configuration input. In single mode, one clear strobe is enough. In paired mode, two different strobes must both arrive, in either order, before the count clears. Entering HALT also clears the count, and so does the external reset.

What a time-out causes depends on the halt status. While the core runs, a time-out pulses a full chip reset request and sets a sticky time-out flag. While the core is halted, a time-out only pulses a warm reset request, which restarts the program counter and stack pointer.

Top module: `wdog_paired_clear`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `chip_rst_req`, `warm_rst_req` and `to_flag` are 0. The count and both paired-clear memories start at zero.
- R2: `src_sel` picks the count enable. 0 selects `tick_rc` and 1 selects `tick_xtal`. 2 and 3 select an internal instruction tick, which is high in every INSTR_DIV-th system clock cycle, starting INSTR_DIV cycles after reset release. The unselected tick inputs have no effect.
- R3: A time-out occurs on the 2^(CNT_W-1)-th tick after the last clear when `long_to` is 0, and on the 2^CNT_W-th tick when `long_to` is 1. The request is high for exactly the one cycle after the clock edge that took that tick. The count then restarts from zero.
- R4: A time-out with `halt` low drives `chip_rst_req` high for one cycle and sets `to_flag` on the same edge.
- R5: A time-out with `halt` high drives `warm_rst_req` high for one cycle. It does not assert `chip_rst_req` and leaves `to_flag` unchanged.
- R6: Once set, `to_flag` stays 1 until `rst_n` goes low.
- R7: A 0-to-1 change of `halt` clears the count.
- R8: With `dual_clr` = 0, `clr_one` clears the count, and `clr_a` and `clr_b` have no effect.
- R9: With `dual_clr` = 1, the count clears on the cycle in which both `clr_a` and `clr_b` have been seen. They may come in either order or in the same cycle. `clr_one` has no effect in this mode.
- R10: The memory of a seen `clr_a` or `clr_b` is discarded whenever the count clears for any reason, including a time-out or a halt entry. It is also discarded whenever `dual_clr` is 0.
- R11: A clear in the same cycle as the tick that would time out wins: no request is made and the count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | External active-low asynchronous reset |
| src_sel | input | 2 | Clock source select (0 RC, 1 crystal, 2/3 instruction) |
| tick_rc | input | 1 | One-cycle enable from the RC oscillator |
| tick_xtal | input | 1 | One-cycle enable from the crystal oscillator |
| long_to | input | 1 | 1 selects the longer time-out period |
| dual_clr | input | 1 | 1 selects the paired-strobe clear scheme |
| clr_one | input | 1 | Single-command clear strobe |
| clr_a | input | 1 | First strobe of the paired clear |
| clr_b | input | 1 | Second strobe of the paired clear |
| halt | input | 1 | High while the core is halted |
| chip_rst_req | output | 1 | One-cycle full chip reset request |
| warm_rst_req | output | 1 | One-cycle warm reset request |
| to_flag | output | 1 | Sticky time-out status |

## Verification
The bench builds the block with CNT_W = 5 and INSTR_DIV = 4. This makes the two time-out periods 16 and 32 ticks, so every period elapses many times within a short run. At those lengths, the exact time-out cycle, a clear that lands on the final tick, and halt entries shortly before expiry can all be hit directly. Random runs then mix the clock sources, clear schemes and halt changes over thousands of cycles, against a cycle-level expected model.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        SRC_RC        = 2'd0,
        SRC_XTAL      = 2'd1,
        SRC_INSTR     = 2'd2,
        SRC_INSTR_ALT = 2'd3
    } wdog_src_e;

    typedef struct packed {
        logic seen_a;
        logic seen_b;
    } clr_state_t;

    typedef struct packed {
        logic halt_q;
        logic chip_rst;
        logic warm_rst;
        logic to_flag;
    } top_state_t;

endpackage

// File: rtl/wdog_tick_sel.sv
module wdog_tick_sel
    import wdog_pkg::*;
#(
    parameter int unsigned INSTR_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src_sel,
    input  logic       tick_rc,
    input  logic       tick_xtal,
    output logic       tick
);
    localparam int unsigned DIV_W = (INSTR_DIV > 2) ? $clog2(INSTR_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(INSTR_DIV - 1);

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } tick_state_t;

    tick_state_t st_d, st_q;
    logic instr_tick;

    always_comb begin
        st_d       = st_q;
        instr_tick = (st_q.div == DIV_LAST);
        st_d.div   = instr_tick ? '0 : st_q.div + 1'b1;
        case (wdog_src_e'(src_sel))
            SRC_RC:   tick = tick_rc;
            SRC_XTAL: tick = tick_xtal;
            default:  tick = instr_tick;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wdog_clear_ctl.sv
module wdog_clear_ctl
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dual_mode,
    input  logic clr_one,
    input  logic clr_a,
    input  logic clr_b,
    input  logic flush,
    output logic clr_now
);
    clr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (dual_mode) clr_now = (clr_a | st_q.seen_a) & (clr_b | st_q.seen_b);
        else           clr_now = clr_one;
        st_d.seen_a = st_q.seen_a | clr_a;
        st_d.seen_b = st_q.seen_b | clr_b;
        if (!dual_mode || clr_now || flush) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wipe,
    input  logic             long_sel,
    output logic             expire,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] LAST_SHORT = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic [CNT_W-1:0] LAST_LONG  = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] last;

    always_comb begin
        last   = long_sel ? LAST_LONG : LAST_SHORT;
        expire = tick & ~wipe & (cnt_q == last);
        cnt_d  = cnt_q;
        if (wipe || expire) cnt_d = '0;
        else if (tick)      cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/wdog_paired_clear.sv
module wdog_paired_clear
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned INSTR_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src_sel,
    input  logic       tick_rc,
    input  logic       tick_xtal,
    input  logic       long_to,
    input  logic       dual_clr,
    input  logic       clr_one,
    input  logic       clr_a,
    input  logic       clr_b,
    input  logic       halt,
    output logic       chip_rst_req,
    output logic       warm_rst_req,
    output logic       to_flag
);
    top_state_t       st_d, st_q;
    logic             tick, clr_now, halt_entry, wipe, flush, expire;
    logic [CNT_W-1:0] cnt_w;

    wdog_tick_sel #(.INSTR_DIV(INSTR_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel),
        .tick_rc(tick_rc), .tick_xtal(tick_xtal), .tick(tick)
    );

    wdog_clear_ctl u_clr (
        .clk(clk), .rst_n(rst_n), .dual_mode(dual_clr), .clr_one(clr_one),
        .clr_a(clr_a), .clr_b(clr_b), .flush(flush), .clr_now(clr_now)
    );

    wdog_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wipe(wipe),
        .long_sel(long_to), .expire(expire), .count(cnt_w)
    );

    always_comb begin
        st_d          = st_q;
        halt_entry    = halt & ~st_q.halt_q;
        wipe          = clr_now | halt_entry;
        flush         = halt_entry | expire;
        st_d.halt_q   = halt;
        st_d.chip_rst = expire & ~halt;
        st_d.warm_rst = expire & halt;
        st_d.to_flag  = st_q.to_flag | (expire & ~halt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign chip_rst_req = st_q.chip_rst;
    assign warm_rst_req = st_q.warm_rst;
    assign to_flag      = st_q.to_flag;
endmodule

// File: rtl/wdog_paired_clear_chk.sv
module wdog_paired_clear_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dual_clr,
    input logic             clr_one,
    input logic             clr_a,
    input logic             clr_b,
    input logic             halt,
    input logic             chip_rst_req,
    input logic             warm_rst_req,
    input logic             to_flag,
    input logic [CNT_W-1:0] cnt_w
);
    p_chip_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst_req |=> !chip_rst_req);
    p_chip_sets_to_r4: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst_req |-> to_flag);
    p_chip_running_r4: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst_req |-> !$past(halt));
    p_warm_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        warm_rst_req |=> !warm_rst_req);
    p_warm_halted_r5: assert property (@(posedge clk) disable iff (!rst_n)
        warm_rst_req |-> $past(halt));
    p_req_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(chip_rst_req && warm_rst_req));
    p_to_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        to_flag |=> to_flag);
    p_halt_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt) |=> (cnt_w == '0));
    p_single_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!dual_clr && clr_one) |=> (cnt_w == '0));
    p_pair_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dual_clr && clr_a && clr_b) |=> (cnt_w == '0));
endmodule

bind wdog_paired_clear wdog_paired_clear_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .dual_clr(dual_clr), .clr_one(clr_one),
    .clr_a(clr_a), .clr_b(clr_b), .halt(halt), .chip_rst_req(chip_rst_req),
    .warm_rst_req(warm_rst_req), .to_flag(to_flag), .cnt_w(cnt_w)
);

// File: tb/tb_wdog_paired_clear.sv
module tb_wdog_paired_clear;
    localparam int unsigned CW = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] src_sel = 2'd0;
    logic       tick_rc = 1'b0, tick_xtal = 1'b0, long_to = 1'b0, dual_clr = 1'b0;
    logic       clr_one = 1'b0, clr_a = 1'b0, clr_b = 1'b0, halt = 1'b0;
    logic       chip_rst_req, warm_rst_req, to_flag;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic [1:0]    div;
        logic [CW-1:0] cnt;
        logic          sa, sb, hq, chip, warm, to;
    } m_t;
    m_t m;

    always #2 clk = ~clk;

    wdog_paired_clear #(.CNT_W(CW), .INSTR_DIV(4)) dut (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .tick_rc(tick_rc),
        .tick_xtal(tick_xtal), .long_to(long_to), .dual_clr(dual_clr),
        .clr_one(clr_one), .clr_a(clr_a), .clr_b(clr_b), .halt(halt),
        .chip_rst_req(chip_rst_req), .warm_rst_req(warm_rst_req), .to_flag(to_flag)
    );

    // Expected next state from the requirements, using current inputs.
    function automatic m_t model_next(m_t s);
        m_t n;
        logic itick, tk, clr, hent, wipe, ex;
        logic [CW-1:0] last;
        n     = s;
        itick = (s.div == 2'd3);
        n.div = s.div + 2'd1;
        case (src_sel)
            2'd0:    tk = tick_rc;
            2'd1:    tk = tick_xtal;
            default: tk = itick;
        endcase
        clr  = dual_clr ? ((clr_a | s.sa) & (clr_b | s.sb)) : clr_one;
        hent = halt & ~s.hq;
        wipe = clr | hent;
        last = long_to ? {CW{1'b1}} : CW'((1 << (CW - 1)) - 1);
        ex   = tk & ~wipe & (s.cnt == last);
        if (wipe || ex) n.cnt = '0;
        else if (tk)    n.cnt = s.cnt + 1'b1;
        if (!dual_clr || clr || hent || ex) begin
            n.sa = 1'b0;
            n.sb = 1'b0;
        end else begin
            n.sa = s.sa | clr_a;
            n.sb = s.sb | clr_b;
        end
        n.hq   = halt;
        n.chip = ex & ~halt;
        n.warm = ex & halt;
        n.to   = s.to | (ex & ~halt);
        return n;
    endfunction

    task automatic compare(input string tag);
        n_checks++;
        if (chip_rst_req !== m.chip || warm_rst_req !== m.warm || to_flag !== m.to) begin
            n_errors++;
            $display("FAIL %s t=%0t chip/warm/to actual=%b%b%b expected=%b%b%b",
                     tag, $time, chip_rst_req, warm_rst_req, to_flag, m.chip, m.warm, m.to);
        end
    endtask

    task automatic step(input string tag);
        m_t nx;
        nx = model_next(m);
        @(posedge clk);
        #1;
        m = nx;
        compare(tag);
    endtask

    task automatic idle_inputs();
        tick_rc = 0; tick_xtal = 0; clr_one = 0; clr_a = 0; clr_b = 0;
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0;
        idle_inputs();
        halt = 0;
        m = '0;
        repeat (2) @(posedge clk);
        #1;
        compare("R1 in reset");
        rst_n = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd2024));

        // R1: reset state
        do_reset();
        step("R1 after release");

        // R3/R4: short period with continuous crystal ticks
        src_sel = 2'd1; tick_xtal = 1; long_to = 0;
        for (int i = 0; i < 40; i++) step("R3 short R4");
        // R6: flag survives clears and time
        clr_one = 1;
        for (int i = 0; i < 10; i++) step("R6");
        clr_one = 0;
        do_reset();
        step("R6 cleared by reset");

        // R3: long period
        src_sel = 2'd1; tick_xtal = 1; long_to = 1;
        for (int i = 0; i < 70; i++) step("R3 long");

        // R5: halted time-out
        do_reset();
        src_sel = 2'd1; tick_xtal = 1; long_to = 0;
        for (int i = 0; i < 20; i++) step("R4 before halt");
        halt = 1;
        for (int i = 0; i < 40; i++) step("R5 halted");
        halt = 0;

        // R11: clear lands on final tick
        do_reset();
        src_sel = 2'd1; tick_xtal = 1; long_to = 0;
        for (int i = 0; i < 15; i++) step("R11 lead");
        clr_one = 1; step("R11 clear on last tick"); clr_one = 0;
        for (int i = 0; i < 15; i++) step("R11 no request");

        // R7: halt entries keep the count short
        do_reset();
        src_sel = 2'd1; tick_xtal = 1;
        for (int i = 0; i < 80; i++) begin
            halt = ((i % 10) == 9);
            step("R7");
        end
        halt = 0;

        // R8: single mode, paired strobes ignored
        do_reset();
        src_sel = 2'd1; tick_xtal = 1; dual_clr = 0;
        for (int i = 0; i < 60; i++) begin
            clr_a = 1'($urandom_range(0, 1));
            clr_b = 1'($urandom_range(0, 1));
            step("R8 pair ignored");
        end
        idle_inputs(); tick_xtal = 1;
        for (int i = 0; i < 60; i++) begin
            clr_one = ((i % 12) == 11);
            step("R8 single clear");
        end
        clr_one = 0;

        // R9: paired mode, both orders, single strobe ignored
        do_reset();
        src_sel = 2'd1; tick_xtal = 1; dual_clr = 1;
        for (int i = 0; i < 90; i++) begin
            clr_one = 1'($urandom_range(0, 1));
            clr_a = ((i % 12) == 3) || ((i % 24) == 22);
            clr_b = ((i % 12) == 9) || ((i % 24) == 14);
            step("R9");
        end
        idle_inputs();

        // R10: memory dropped by halt entry, by time-out and by mode change
        do_reset();
        src_sel = 2'd1; tick_xtal = 1; dual_clr = 1;
        clr_a = 1; step("R10 a"); clr_a = 0;
        halt = 1; step("R10 halt entry"); halt = 0;
        for (int i = 0; i < 3; i++) step("R10");
        clr_b = 1; step("R10 b alone"); clr_b = 0;
        for (int i = 0; i < 30; i++) step("R10 expire");
        clr_a = 1; step("R10 a2"); clr_a = 0;
        dual_clr = 0; step("R10 mode off"); dual_clr = 1;
        clr_b = 1; step("R10 b2 alone"); clr_b = 0;
        for (int i = 0; i < 20; i++) step("R10 tail");

        // R2: each source, noise on the others
        for (int s = 0; s < 4; s++) begin
            do_reset();
            src_sel = 2'(s); dual_clr = 0;
            for (int i = 0; i < 200; i++) begin
                tick_rc   = ($urandom_range(0, 3) == 0);
                tick_xtal = ($urandom_range(0, 1) == 0);
                step("R2 source");
            end
        end

        // Random mix of all inputs
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            if ((i % 500) == 0) begin
                src_sel  = 2'($urandom_range(0, 3));
                long_to  = 1'($urandom_range(0, 1));
                dual_clr = 1'($urandom_range(0, 1));
            end
            tick_rc   = ($urandom_range(0, 2) == 0);
            tick_xtal = ($urandom_range(0, 1) == 0);
            clr_one   = ($urandom_range(0, 40) == 0);
            clr_a     = ($urandom_range(0, 30) == 0);
            clr_b     = ($urandom_range(0, 30) == 0);
            if ($urandom_range(0, 60) == 0) halt = ~halt;
            step("mix R4 R5 R9");
        end

        if (!done) begin
            done = 1'b1;
            $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule